// File: doc/BRIEF.md
# Two-Phase Array Sum Sequencer

This block sums an array of N integers that sits in a local memory. It reads one word per cycle through a read port and keeps a bank of LANES partial sums, where LANES is a power of two. In the first phase it clears every partial sum and then spreads the array across the lanes in chunks. If N is not a whole number of chunks, the short leftover chunk is handled first and every chunk after it is full width. In the second phase it collapses the partial-sum bank in a halving tree. Each fold cycle adds the upper half of the active lanes into the lower half, until only lane 0 is left.

The caller presents N together with a start pulse, answers the read requests from its memory, and picks up the total when done pulses. All arithmetic wraps modulo 2^DATA_W and no overflow is reported. The read port has a latency of one cycle: data for an address asserted in one cycle is expected on `rd_data` in the next cycle.

Top module: `vsum_tree_seq`

## Requirements
- R1: A start pulse seen while idle latches N and clears all LANES partial sums to zero, so a run never inherits state from the previous run.
- R2: For N > 0, `rd_en` is high for exactly N consecutive cycles beginning the cycle after start, with `rd_addr` taking the values 0, 1, ..., N-1 in that order.
- R3: When N mod LANES is nonzero, the first N mod LANES elements fill lanes 0 upward and later chunks use all LANES lanes. Lanes outside the current chunk contribute zero. The final result is the sum of elements 0 to N-1.
- R4: All sums wrap modulo 2^DATA_W.
- R5: The fold phase takes log2(LANES) cycles. `done` rises after exactly N + log2(LANES) + 2 rising edges, counting the edge that sampled start.
- R6: `done` is high for exactly one cycle, and `result` holds the total in that cycle. `result` keeps that value until the next accepted start.
- R7: N = 0 yields a result of 0, with no reads.
- R8: A start pulse that arrives while a run is in progress is ignored: the ongoing run's reads, timing and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| n_elems | input | ADDR_W+1 | Number of elements to sum |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | DATA_W | Memory read data, one cycle after request |
| result | output | DATA_W | Total, valid when done is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
With the default eight lanes, the total is due N + 5 cycles after start: N read cycles, one cycle to absorb the last returned word, three fold cycles, and the cycle that presents the output. The bench drives inputs on falling edges and samples on falling edges, so every observed value reflects completed register updates. It counts the edges between start and the first sample with `done` high and compares that count against the formula. The read strobes and addresses are checked on the same falling edges. The done width and the result hold are checked on the falling edge after the pulse.

// File: rtl/vsum_pkg.sv
package vsum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DRAIN,
        ST_FOLD,
        ST_DONE
    } seq_state_t;

    function automatic bit is_pow2(input int unsigned v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/vsum_addr_gen.sv
module vsum_addr_gen #(
    parameter int CNT_W = 7,
    parameter int LANES = 8,
    localparam int LW   = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] n_in,
    input  logic             step,
    output logic [CNT_W-1:0] idx,
    output logic [LW-1:0]    lane,
    output logic             last
);
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] idx_q;
    logic [LW-1:0]    lane_q;
    logic [LW:0]      len_q;
    logic [LW:0]      first_len;
    logic [LW:0]      len_m1;
    logic [LW-1:0]    rem;

    assign rem       = n_in[LW-1:0];
    assign first_len = (rem == '0) ? (LW+1)'(LANES) : {1'b0, rem};
    assign len_m1    = len_q - (LW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q    <= '0;
            idx_q  <= '0;
            lane_q <= '0;
            len_q  <= (LW+1)'(LANES);
        end else if (load) begin
            n_q    <= n_in;
            idx_q  <= '0;
            lane_q <= '0;
            len_q  <= first_len;
        end else if (step) begin
            idx_q <= idx_q + CNT_W'(1);
            if ({1'b0, lane_q} == len_m1) begin
                lane_q <= '0;
                len_q  <= (LW+1)'(LANES);
            end else begin
                lane_q <= lane_q + LW'(1);
            end
        end
    end

    assign idx  = idx_q;
    assign lane = lane_q;
    assign last = (idx_q == n_q - CNT_W'(1));

    // R3
    lane_in_chunk_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ({1'b0, lane_q} < len_q));

endmodule

// File: rtl/vsum_lanes.sv
module vsum_lanes #(
    parameter int DATA_W = 32,
    parameter int LANES  = 8,
    localparam int LW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [LW-1:0]     acc_lane,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              fold_en,
    input  logic [LW-1:0]     fold_half,
    output logic [DATA_W-1:0] sum0
);
    logic [DATA_W-1:0] part [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LW-1:0] src;
        assign src = LW'(j) + fold_half;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                part[j] <= '0;
            end else if (acc_en && (acc_lane == LW'(j))) begin
                part[j] <= part[j] + acc_data;
            end else if (fold_en && (LW'(j) < fold_half)) begin
                part[j] <= part[j] + part[src];
            end
        end
    end

    assign sum0 = part[0];

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum0 == '0));

    // R5
    fold_no_acc_chk: assert property (@(posedge clk) disable iff (rst)
        fold_en |-> !acc_en);

endmodule

// File: rtl/vsum_tree_seq.sv
module vsum_tree_seq
    import vsum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    localparam int CNT_W = ADDR_W + 1,
    localparam int LW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  n_elems,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    seq_state_t      state_q;
    logic [LW-1:0]   half_q;
    logic            pend_vld_q;
    logic [LW-1:0]   pend_lane_q;
    logic            accept;
    logic            fetch;
    logic [CNT_W-1:0] idx;
    logic [LW-1:0]   lane;
    logic            last;
    logic [DATA_W-1:0] sum0;

    initial begin
        if (!is_pow2(LANES)) $error("LANES must be a power of two >= 2");
    end

    assign accept = (state_q == ST_IDLE) && start;
    assign fetch  = (state_q == ST_LOAD);

    vsum_addr_gen #(.CNT_W(CNT_W), .LANES(LANES)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .n_in (n_elems),
        .step (fetch),
        .idx  (idx),
        .lane (lane),
        .last (last)
    );

    vsum_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .acc_en    (pend_vld_q),
        .acc_lane  (pend_lane_q),
        .acc_data  (rd_data),
        .fold_en   (state_q == ST_FOLD),
        .fold_half (half_q),
        .sum0      (sum0)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            half_q      <= '0;
            pend_vld_q  <= 1'b0;
            pend_lane_q <= '0;
        end else begin
            pend_vld_q  <= fetch;
            pend_lane_q <= lane;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= (n_elems == '0) ? ST_DRAIN : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (last) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    state_q <= ST_FOLD;
                    half_q  <= LW'(LANES / 2);
                end
                ST_FOLD: begin
                    if (half_q == LW'(1)) state_q <= ST_DONE;
                    else                  half_q  <= half_q >> 1;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_en   = fetch;
    assign rd_addr = idx[ADDR_W-1:0];
    assign result  = sum0;
    assign done    = (state_q == ST_DONE);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    addr_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> (rd_addr == '0));

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_en);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(done) && !accept |-> $stable(result));

endmodule

// File: tb/test_vsum_tree_seq.sv
module test_vsum_tree_seq;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int LANES  = 8;
    localparam int LOG2L  = 3;
    localparam int CNT_W  = ADDR_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] n_elems = '0;
    logic rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] result;
    logic done;

    logic [DATA_W-1:0] mem [1<<ADDR_W];

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    vsum_tree_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) i_vsum_tree_seq (
        .clk(clk), .rst(rst), .start(start), .n_elems(n_elems),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .result(result), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [DATA_W-1:0] base, input logic [DATA_W-1:0] inc);
        for (int k = 0; k < (1 << ADDR_W); k++) mem[k] = base + DATA_W'(k) * inc;
    endtask

    function automatic logic [DATA_W-1:0] ref_sum(input int n);
        logic [DATA_W-1:0] s = '0;
        for (int k = 0; k < n; k++) s = s + mem[k];
        return s;
    endfunction

    // Runs one sum; optionally pulses start with another N while busy.
    task automatic run(input int n, input string req, input bit poke);
        int cyc = 0;
        int reads = 0;
        int addr_bad = 0;
        bit hung = 0;
        logic [DATA_W-1:0] exp = ref_sum(n);
        @(negedge clk);
        n_elems = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done) begin
            if (rd_en) begin
                if (rd_addr != ADDR_W'(reads)) addr_bad++;
                reads++;
            end
            if (poke && cyc == 2) begin
                n_elems = CNT_W'(3);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 1000) begin hung = 1; break; end
        end
        start = 1'b0;
        if (hung) begin
            checks++; fails++;
            $display("FAIL %s watchdog actual=hung expected=done", req);
            return;
        end
        check({req, " R3 R4 result"}, 64'(result), 64'(exp));
        check({req, " R2 read count"}, 64'(reads), 64'(n));
        check({req, " R2 address order"}, 64'(addr_bad), 64'd0);
        check({req, " R5 latency"}, 64'(cyc), 64'(n + LOG2L + 2));
        @(negedge clk);
        check({req, " R6 done one cycle"}, 64'(done), 64'd0);
        check({req, " R6 result held"}, 64'(result), 64'(exp));
    endtask

    task automatic t_reset;
        check("R6 reset done low", 64'(done), 64'd0);
        check("R2 reset no read", 64'(rd_en), 64'd0);
    endtask

    task automatic t_remainder;
        fill(32'd1, 32'd3);
        run(13, "R3 remainder", 1'b0);
        run(1, "R3 single", 1'b0);
    endtask

    task automatic t_full;
        fill(32'd7, 32'd11);
        run(16, "R3 whole chunks", 1'b0);
        run(64, "R3 full memory", 1'b0);
    endtask

    task automatic t_clear;
        // a nonzero previous result must not leak into this run (R1)
        fill(32'h100, 32'd5);
        run(5, "R1 fresh partials", 1'b0);
    endtask

    task automatic t_wrap;
        fill(32'hF000_0000, 32'h0100_0000);
        run(20, "R4 wrap", 1'b0);
    endtask

    task automatic t_zero;
        fill(32'hDEAD_BEEF, 32'd1);
        run(0, "R7 empty", 1'b0);
    endtask

    task automatic t_busy_start;
        fill(32'd2, 32'd9);
        run(11, "R8 start ignored", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_remainder();
        t_full();
        t_clear();
        t_wrap();
        t_zero();
        t_busy_start();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule